// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block is a read-only, direct-mapped cache placed between a requester and a slower backing memory. The requester presents a byte address with a valid/ready handshake. The block splits that address into a tag, a line index and a byte offset, and looks up the indexed line. On a hit, it returns the addressed byte one cycle after the request is accepted.

On a miss, the controller stops accepting requests. It asks the backing memory for the whole block that contains the address, and writes the returned block into the indexed line together with its tag and valid bit. It then answers the waiting request from the refilled line and marks the answer as a miss.

Each line holds 2^OFS_W bytes, and there are 2^IDX_W lines. A refill always replaces whatever the indexed line held before. The memory port takes a held request and returns one full block in a single-cycle response.

Top module: `dm_read_cache`

## Requirements
- R1: The request address is split as follows: bits [OFS_W-1:0] are the byte offset, the next IDX_W bits are the line index, and the remaining upper bits are the tag. Addresses that differ only in the tag map to the same line but do not hit each other's data.
- R2: Reset clears every line's valid bit, so the first access to each line after reset is handled as a miss.
- R3: A request hits only if the indexed line is valid and its stored tag equals the request tag. A hit answers with rsp_valid=1 and rsp_miss=0 in the cycle right after the request is accepted.
- R4: The returned byte is byte number `offset` of the line. Byte i of a memory block travels on mem_rsp_data[8i+7:8i] and is stored as byte i of the line.
- R5: On a miss, mem_req_valid rises in the cycle after the lookup and stays high until the cycle in which mem_rsp_valid is sampled. During that time req_ready and rsp_valid stay low.
- R6: mem_req_addr carries the request address with its offset bits forced to zero.
- R7: The refill writes the tag, the block data and a set valid bit into the indexed line. In the next cycle the pending request is answered with rsp_valid=1 and rsp_miss=1, and mem_req_valid is low.
- R8: A refill overwrites the indexed line unconditionally. After a conflicting block has been loaded, an access to the block that was evicted misses again.
- R9: req_ready is high only while no request is in flight. A request is accepted only on a cycle where req_valid and req_ready are both high, and at most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester presents an address |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Response byte is valid this cycle |
| rsp_data | output | 8 | Returned byte |
| rsp_miss | output | 1 | Response came from a refill |
| mem_req_valid | output | 1 | Block fetch request, held until answered |
| mem_req_addr | output | ADDR_W | Block-aligned fetch address |
| mem_rsp_valid | input | 1 | Memory returns the block this cycle |
| mem_rsp_data | input | 8*2^OFS_W | Returned block, byte i in bits [8i+7:8i] |

## Verification
The bench checks the following cases and the faulty behaviour each one would expose:
- First touches of every line after reset: a design that leaves valid bits unreset would answer them as hits with garbage data.
- Two addresses that share an index but differ only in the top tag bit, accessed alternately: a design that compares a truncated tag or skips the overwrite would return stale bytes, or would hit where it should miss.
- Every offset within a refilled block, including the last byte: a wrong byte lane in the multiplexer or in the fill would show up there.
- Memory latencies varied from one to several cycles: a controller that drops the held request, or that answers before the block arrives, would break the exact response timing the bench samples.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2,
    ST_REPLY  = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int OFS_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFS_W-1:0]  ofs
);
  // R1: offset low, index middle, tag upper
  assign ofs = addr[OFS_W-1:0];
  assign idx = addr[OFS_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7,
  parameter int BLK_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_blk
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BLK_W-1:0] blk_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic line_we;
    assign line_we = wr_en && (wr_idx == IDX_W'(i));

    // R2: valid bits cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (line_we) begin
        valid_q[i] <= 1'b1;
      end
    end

    // R7/R8: tag and data overwritten unconditionally on fill
    always_ff @(posedge clk) begin
      if (line_we) begin
        tag_q[i] <= wr_tag;
        blk_q[i] <= wr_blk;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_blk   = blk_q[rd_idx];

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]); // R7
endmodule

// File: rtl/dmc_byte_sel.sv
module dmc_byte_sel #(
  parameter int OFS_W = 2,
  localparam int NBYTES = 1 << OFS_W,
  localparam int BLK_W  = 8 * NBYTES
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [OFS_W-1:0] ofs,
  output logic [7:0]       byte_out
);
  logic [7:0] lane [NBYTES];

  // R4: byte i of the block sits in bits [8i+7:8i]
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign lane[i] = blk[8*i +: 8];
  end

  assign byte_out = lane[ofs];
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int OFS_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int BLK_W = 8 * (1 << OFS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              rsp_miss,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [BLK_W-1:0]  mem_rsp_data
);
  import dmc_pkg::*;

  dmc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;
  logic [TAG_W-1:0]  cur_tag;
  logic [IDX_W-1:0]  cur_idx;
  logic [OFS_W-1:0]  cur_ofs;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [BLK_W-1:0]  line_blk;
  logic              hit;
  logic              fill_we;

  dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_split (
    .addr (addr_q),
    .tag  (cur_tag),
    .idx  (cur_idx),
    .ofs  (cur_ofs)
  );

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fill_we),
    .wr_idx   (cur_idx),
    .wr_tag   (cur_tag),
    .wr_blk   (mem_rsp_data),
    .rd_idx   (cur_idx),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_blk   (line_blk)
  );

  dmc_byte_sel #(.OFS_W(OFS_W)) u_sel (
    .blk      (line_blk),
    .ofs      (cur_ofs),
    .byte_out (rsp_data)
  );

  // R3: hit needs valid line and equal tag
  assign hit     = line_valid && (line_tag == cur_tag);
  assign addr_en = req_valid && req_ready;
  assign fill_we = (state_q == ST_FILL) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (addr_en) state_d = ST_LOOKUP;
      ST_LOOKUP: state_d = hit ? ST_IDLE : ST_FILL;
      ST_FILL:   if (mem_rsp_valid) state_d = ST_REPLY;
      ST_REPLY:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= req_addr;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = ((state_q == ST_LOOKUP) && hit) || (state_q == ST_REPLY);
  assign rsp_miss      = (state_q == ST_REPLY);
  assign mem_req_valid = (state_q == ST_FILL);
  // R6: block-aligned fetch address
  assign mem_req_addr  = {cur_tag, cur_idx, {OFS_W{1'b0}}};

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_rsp_valid |=> mem_req_valid); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R9
  AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> $past(mem_rsp_valid && mem_req_valid)); // R7
  AST_HIT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_miss |-> $past(req_valid && req_ready)); // R3
  AST_NO_RSP_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready); // R5
endmodule

// File: tb/dm_read_cache_test.sv
module dm_read_cache_test;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int OFS_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int NB     = 1 << OFS_W;
  localparam int BLK_W  = 8 * NB;
  localparam int LINES  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic [7:0]        rsp_data;
  logic              rsp_miss;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [BLK_W-1:0]  mem_rsp_data;

  int checks = 0;
  int errors = 0;

  bit             mdl_vld [LINES];
  logic [TAG_W-1:0] mdl_tag [LINES];

  always #4 clk = ~clk;

  dm_read_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_miss(rsp_miss), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    logic [15:0] t = 16'(a) * 16'd29 + 16'(a >> 5);
    return t[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [BLK_W-1:0] mem_block(input logic [ADDR_W-1:0] a);
    logic [BLK_W-1:0] b = '0;
    logic [ADDR_W-1:0] base = a & ~ADDR_W'(NB - 1);
    for (int i = 0; i < NB; i++) b[8*i +: 8] = mem_byte(base + ADDR_W'(i));
    return b;
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx, input int ofs);
    return ADDR_W'((tag << (IDX_W + OFS_W)) | (idx << OFS_W) | ofs);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input string cls_req);
    int idx = int'(a[OFS_W +: IDX_W]);
    logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
    bit exp_hit = mdl_vld[idx] && (mdl_tag[idx] == tg);
    int lat = 1 + int'($urandom % 5);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === exp_hit, cls_req, "hit/miss classification", int'(rsp_valid), int'(exp_hit));
    chk(req_ready === 1'b0, "R9", "no accept while busy", int'(req_ready), 0);
    if (exp_hit) begin
      chk(rsp_miss === 1'b0, "R3", "miss flag on hit", int'(rsp_miss), 0);
      chk(rsp_data === mem_byte(a), "R4", "hit data", int'(rsp_data), int'(mem_byte(a)));
    end else begin
      @(negedge clk);
      chk(mem_req_valid === 1'b1, "R5", "fetch request raised", int'(mem_req_valid), 1);
      chk(mem_req_addr === (a & ~ADDR_W'(NB - 1)), "R6", "aligned fetch address",
          int'(mem_req_addr), int'(a & ~ADDR_W'(NB - 1)));
      for (int c = 1; c < lat; c++) begin
        @(negedge clk);
        chk(mem_req_valid === 1'b1 && req_ready === 1'b0 && rsp_valid === 1'b0,
            "R5", "stall while fetching", int'({mem_req_valid, req_ready, rsp_valid}), 4);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_block(a);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      chk(rsp_valid === 1'b1 && rsp_miss === 1'b1, "R7", "miss response after fill",
          int'({rsp_valid, rsp_miss}), 3);
      chk(rsp_data === mem_byte(a), "R4", "fill data", int'(rsp_data), int'(mem_byte(a)));
      chk(mem_req_valid === 1'b0, "R7", "fetch dropped", int'(mem_req_valid), 0);
      mdl_vld[idx] = 1'b1;
      mdl_tag[idx] = tg;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin
      mdl_vld[i] = 1'b0;
      mdl_tag[i] = '0;
    end
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R2",
        "reset state", int'({req_ready, rsp_valid, mem_req_valid}), 4);

    // R2: first touch of each line misses
    for (int i = 0; i < LINES; i++) access(mk_addr(5, i, 0), "R2");
    // R4: every offset of each filled line hits
    for (int i = 0; i < LINES; i++)
      for (int o = 0; o < NB; o++) access(mk_addr(5, i, o), "R4");
    // R1: differing only in top tag bit -> same line, miss
    access(mk_addr((1 << (TAG_W - 1)) | 5, 2, NB - 1), "R1");
    access(mk_addr((1 << (TAG_W - 1)) | 5, 2, 1), "R1");
    // R8: evicted block misses again
    access(mk_addr(5, 2, 3), "R8");
    access(mk_addr((1 << TAG_W) - 1, 7, NB - 1), "R8");
    access(mk_addr(5, 7, 0), "R8");

    for (int n = 0; n < 400; n++)
      access(mk_addr(int'($urandom % 4), int'($urandom % LINES), int'($urandom % NB)), "R3");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule